// File: doc/BRIEF.md
# Gated Instruction Ring

This block is the per-slot instruction ring of an offload engine. Fixed-size instruction records (eight 64-bit words, 512 bits) are pushed in by the producer, held in an on-block ring and offered one at a time, oldest first, to an execution port. Software sets the ring through four 64-bit registers. One register holds the ring base address. One holds the ring size in groups of 40 records. One holds an accept enable that gates new pushes. A status register holds a separate dispatch enable, a sticky drop flag, the count of records dispatched but not yet completed, and the count of records waiting in the ring.

One group of 40 slots is always held back, so the usable depth is (groups − 1) × 40. To shut the slot down, software clears the accept enable, polls the in-flight field until it reads zero, and then clears the dispatch enable. To start it, software sets the dispatch enable first and then the accept enable. A push that the ring cannot take is dropped and latched in the sticky flag.

Top module: `inst_queue_gate`

## Requirements
- R1: After a synchronous active-low reset, all four registers read zero and `exec_valid` is low.
- R2: The groups register (address 1, bits [15:0]) stores the ring size in groups of 40 slots. A value above MAX_GROUPS (default 3) is stored and read back as MAX_GROUPS. Any write to it empties the ring.
- R3: The usable depth is (groups − 1) × 40 records, and zero when groups is 0 or 1. A push is accepted only while the queued count is below that depth.
- R4: The base register (address 0) keeps bits [63:7] of the written value and reads zero in bits [6:0] (128-byte alignment).
- R5: While the accept enable (address 2, bit 0) is clear, every push is refused and the queued count does not rise.
- R6: A refused push sets the sticky drop flag (address 3, bit 1). The flag stays set until a status write with bit 1 set clears it. A write with bit 1 clear leaves it unchanged.
- R7: `exec_valid` is high exactly when the dispatch enable (address 3, bit 0) is set, the ring is not empty and the in-flight count is below 255. Records leave on `exec_rec` in push order, one per cycle in which `exec_valid` and `exec_ready` are both high.
- R8: The in-flight count (address 3, bits [23:16]) rises by one per dispatch and falls by one per `done_strobe`. A dispatch and a strobe in the same cycle leave it unchanged. A strobe while it is zero has no effect.
- R9: The queued count (address 3, bits [38:32]) reports the records held in the ring. Clearing the accept enable does not stop dispatch, so the ring drains to zero while the dispatch enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| push_valid | input | 1 | Push attempt this cycle |
| push_rec | input | 512 | Instruction record to push |
| exec_valid | output | 1 | Head record is offered for execution |
| exec_ready | input | 1 | Execution side takes the offered record |
| exec_rec | output | 512 | Head record |
| done_strobe | input | 1 | One dispatched instruction has completed |

## Verification
The assertions assume that the execution side never strobes `done_strobe` for more instructions than were dispatched, apart from stray strobes at zero, which the block must ignore. They also assume that register writes do not coincide with pushes or dispatches. The bench keeps to both assumptions: every register write is issued with `push_valid` and `exec_ready` held low, and random strobes are free to arrive at a zero count only because that case is defined. The random phase mixes pushes, ready, strobes and occasional toggles of both enables. A bench model predicts the status word and the head record every cycle.

// File: rtl/iqg_pkg.sv
// Package: register addresses and status-field positions shared by the
// instruction ring and its bench-visible register map.
package iqg_pkg;
    localparam logic [1:0] RA_BASE   = 2'd0;
    localparam logic [1:0] RA_GROUPS = 2'd1;
    localparam logic [1:0] RA_CTRL   = 2'd2;
    localparam logic [1:0] RA_PROG   = 2'd3;

    localparam int BASE_ALIGN_BITS = 7;
    localparam int GROUP_FIELD_W   = 16;
    localparam int ST_EXEC_BIT     = 0;
    localparam int ST_DROP_BIT     = 1;
    localparam int ST_INFL_LSB     = 16;
    localparam int ST_QCNT_LSB     = 32;
endpackage

// File: rtl/iqg_regs.sv
// Module: iqg_regs
// Holds the software-visible state: aligned base, clamped group count,
// accept enable, dispatch enable and the sticky drop flag; muxes read data.
// Assumes DATA_W is wide enough to hold the status fields.
module iqg_regs #(
    parameter int DATA_W     = 64,
    parameter int MAX_GROUPS = 3,
    parameter int GRP_W      = 2,
    parameter int INFL_W     = 8,
    parameter int CNT_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drop,
    input  logic [INFL_W-1:0] inflight,
    input  logic [CNT_W-1:0]  queued,
    output logic [DATA_W-1:0] rdata,
    output logic [GRP_W-1:0]  groups,
    output logic              accept_en,
    output logic              exec_en,
    output logic              groups_wr
);
    import iqg_pkg::*;

    logic [DATA_W-1:0] base_q;
    logic [GRP_W-1:0]  groups_q;
    logic              accept_q;
    logic              exec_q;
    logic              drop_q;
    logic [GROUP_FIELD_W-1:0] req_groups;

    assign req_groups = wdata[GROUP_FIELD_W-1:0];
    assign groups_wr  = wen && (addr == RA_GROUPS);

    // Register writes for base, groups and both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            groups_q <= '0;
            accept_q <= 1'b0;
            exec_q   <= 1'b0;
        end else if (wen) begin
            case (addr)
                RA_BASE:   base_q <= {wdata[DATA_W-1:BASE_ALIGN_BITS], {BASE_ALIGN_BITS{1'b0}}};
                RA_GROUPS: begin
                    if (req_groups > GROUP_FIELD_W'(MAX_GROUPS))
                        groups_q <= GRP_W'(MAX_GROUPS);
                    else
                        groups_q <= req_groups[GRP_W-1:0];
                end
                RA_CTRL:   accept_q <= wdata[0];
                default:   exec_q   <= wdata[ST_EXEC_BIT];
            endcase
        end
    end

    // Sticky drop flag: set by a refused push, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= 1'b0;
        else if (drop)
            drop_q <= 1'b1;
        else if (wen && addr == RA_PROG && wdata[ST_DROP_BIT])
            drop_q <= 1'b0;
    end

    // Read mux; status word assembled from live counters.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_BASE:   rdata = base_q;
            RA_GROUPS: rdata[GRP_W-1:0] = groups_q;
            RA_CTRL:   rdata[0] = accept_q;
            default: begin
                rdata[ST_EXEC_BIT]             = exec_q;
                rdata[ST_DROP_BIT]             = drop_q;
                rdata[ST_INFL_LSB +: INFL_W]   = inflight;
                rdata[ST_QCNT_LSB +: CNT_W]    = queued;
            end
        endcase
    end

    assign groups    = groups_q;
    assign accept_en = accept_q;
    assign exec_en   = exec_q;

    assert_drop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> drop_q);
endmodule

// File: rtl/iqg_ring.sv
// Module: iqg_ring
// Ring storage with head/tail pointers wrapping at the programmed capacity.
// Assumes the caller never pushes when full nor pops when empty; clear wins.
module iqg_ring #(
    parameter int SLOTS = 120,
    parameter int REC_W = 512,
    parameter int PTR_W = 7,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [REC_W-1:0] push_rec,
    input  logic             pop,
    output logic [REC_W-1:0] head_rec,
    output logic [CNT_W-1:0] queued
);
    logic [REC_W-1:0] mem [SLOTS];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                   input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] pe;
        pe = CNT_W'(p) + CNT_W'(1);
        return (pe >= c) ? '0 : pe[PTR_W-1:0];
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= step_ptr(tail_q, cap);
            if (pop)  head_q <= step_ptr(head_q, cap);
            case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Record storage write.
    always_ff @(posedge clk) begin
        if (push && !clear) mem[tail_q] <= push_rec;
    end

    assign head_rec = mem[head_q];
    assign queued   = count_q;
endmodule

// File: rtl/iqg_track.sv
// Module: iqg_track
// In-flight counter: up on dispatch, down on completion, never below zero.
// Assumes fire is withheld while the counter is at its maximum.
module iqg_track #(
    parameter int INFL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              done,
    output logic [INFL_W-1:0] inflight,
    output logic              at_max
);
    logic [INFL_W-1:0] cnt_q;
    logic              dec;

    assign dec = done && (cnt_q != '0);

    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else case ({fire, dec})
            2'b10:   cnt_q <= cnt_q + INFL_W'(1);
            2'b01:   cnt_q <= cnt_q - INFL_W'(1);
            default: cnt_q <= cnt_q;
        endcase
    end

    assign inflight = cnt_q;
    assign at_max   = (cnt_q == '1);

    assert_count_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !done) |=> inflight == $past(inflight) + INFL_W'(1));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == '0 && !fire) |=> inflight == '0);
endmodule

// File: rtl/inst_queue_gate.sv
// Module: inst_queue_gate
// Top of the gated instruction ring: register file, ring and in-flight
// tracker. Assumes register writes do not coincide with push or dispatch.
module inst_queue_gate #(
    parameter int GROUP_SLOTS = 40,
    parameter int MAX_GROUPS  = 3,
    parameter int REC_WORDS   = 8,
    parameter int WORD_W      = 64,
    parameter int INFL_W      = 8,
    parameter int DATA_W      = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wen,
    input  logic [1:0]                  reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        push_valid,
    input  logic [REC_WORDS*WORD_W-1:0] push_rec,
    output logic                        exec_valid,
    input  logic                        exec_ready,
    output logic [REC_WORDS*WORD_W-1:0] exec_rec,
    input  logic                        done_strobe
);
    localparam int REC_W = REC_WORDS * WORD_W;
    localparam int SLOTS = MAX_GROUPS * GROUP_SLOTS;
    localparam int PTR_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int GRP_W = $clog2(MAX_GROUPS + 1);

    logic [GRP_W-1:0]  groups;
    logic              accept_en, exec_en, groups_wr;
    logic [CNT_W-1:0]  cap, usable, queued;
    logic [INFL_W-1:0] inflight;
    logic              infl_max, take, drop, fire;

    // Capacity and usable depth from the programmed group count.
    always_comb begin
        cap    = CNT_W'(int'(groups) * GROUP_SLOTS);
        usable = (groups == '0) ? '0 : CNT_W'((int'(groups) - 1) * GROUP_SLOTS);
    end

    assign take       = push_valid && accept_en && (queued < usable) && !groups_wr;
    assign drop       = push_valid && !take;
    assign exec_valid = exec_en && (queued != '0) && !infl_max;
    assign fire       = exec_valid && exec_ready;

    iqg_regs #(
        .DATA_W(DATA_W), .MAX_GROUPS(MAX_GROUPS), .GRP_W(GRP_W),
        .INFL_W(INFL_W), .CNT_W(CNT_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .drop(drop), .inflight(inflight), .queued(queued),
        .rdata(reg_rdata), .groups(groups), .accept_en(accept_en),
        .exec_en(exec_en), .groups_wr(groups_wr)
    );

    iqg_ring #(
        .SLOTS(SLOTS), .REC_W(REC_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) ring_i (
        .clk(clk), .rst_n(rst_n), .clear(groups_wr), .cap(cap),
        .push(take), .push_rec(push_rec), .pop(fire),
        .head_rec(exec_rec), .queued(queued)
    );

    iqg_track #(
        .INFL_W(INFL_W)
    ) track_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .done(done_strobe),
        .inflight(inflight), .at_max(infl_max)
    );

    assert_queue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        queued <= usable);
    assert_accept_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_en |=> queued <= $past(queued));
    assert_exec_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> inflight <= $past(inflight));
    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && exec_ready && !infl_max && queued != '0 && !reg_wen) |=>
        queued < $past(queued) || $past(take));
endmodule

// File: tb/inst_queue_gate_tb_top.sv
`timescale 1ns/1ps
module inst_queue_gate_tb_top;
    localparam int REC_W = 512;
    localparam real PERIOD = 20.0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wen = 1'b0;
    logic [1:0]       reg_addr = 2'd3;
    logic [63:0]      reg_wdata = '0;
    logic [63:0]      reg_rdata;
    logic             push_valid = 1'b0;
    logic [REC_W-1:0] push_rec = '0;
    logic             exec_valid;
    logic             exec_ready = 1'b0;
    logic [REC_W-1:0] exec_rec;
    logic             done_strobe = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // bench model
    logic [63:0]      m_base = '0;
    int               m_grp = 0;
    logic             m_ena = 0, m_een = 0, m_ovf = 0;
    int               m_infl = 0;
    logic [REC_W-1:0] mq[$];

    always #(PERIOD/2) clk = ~clk;

    inst_queue_gate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
        .push_rec(push_rec), .exec_valid(exec_valid), .exec_ready(exec_ready),
        .exec_rec(exec_rec), .done_strobe(done_strobe)
    );

    function automatic int usable_of(input int g);
        return (g > 0) ? (g - 1) * 40 : 0;
    endfunction

    function automatic logic [63:0] exp_status();
        logic [63:0] s;
        s = '0;
        s[0] = m_een;
        s[1] = m_ovf;
        s[16 +: 8] = 8'(m_infl);
        s[32 +: 7] = 7'(mq.size());
        return s;
    endfunction

    function automatic logic m_exec_valid();
        return m_een && (mq.size() > 0) && (m_infl < 255);
    endfunction

    function automatic logic [REC_W-1:0] rnd_rec();
        logic [REC_W-1:0] r;
        for (int i = 0; i < REC_W/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input logic ok, input string what,
                         input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One clock: check outputs mid-cycle, advance model at the edge.
    task automatic cycle();
        logic mv, acc, refused, fire, dec;
        #1;
        mv = m_exec_valid();
        check(exec_valid === mv, "exec_valid", REC_W'(exec_valid), REC_W'(mv));
        if (mv) check(exec_rec === mq[0], "exec_rec", exec_rec, mq[0]);
        if (!reg_wen && reg_addr == 2'd3)
            check(reg_rdata === exp_status(), "status", REC_W'(reg_rdata), REC_W'(exp_status()));
        @(posedge clk);
        fire    = mv && exec_ready;
        acc     = push_valid && m_ena && (mq.size() < usable_of(m_grp));
        refused = push_valid && !acc;
        dec     = done_strobe && (m_infl > 0);
        if (refused) m_ovf = 1;
        else if (reg_wen && reg_addr == 2'd3 && reg_wdata[1]) m_ovf = 0;
        if (fire) void'(mq.pop_front());
        if (acc) mq.push_back(push_rec);
        m_infl = m_infl + (fire ? 1 : 0) - (dec ? 1 : 0);
        if (reg_wen) begin
            case (reg_addr)
                2'd0: m_base = {reg_wdata[63:7], 7'b0};
                2'd1: begin
                    m_grp = (reg_wdata[15:0] > 16'd3) ? 3 : int'(reg_wdata[15:0]);
                    mq.delete();
                end
                2'd2: m_ena = reg_wdata[0];
                default: m_een = reg_wdata[0];
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        push_valid = 1'b0; exec_ready = 1'b0; done_strobe = 1'b0;
        cycle();
        reg_wen = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [63:0] exp, input string what);
        reg_addr = a;
        #2;
        check(reg_rdata === exp, what, REC_W'(reg_rdata), REC_W'(exp));
        reg_addr = 2'd3;
    endtask

    task automatic idle();
        push_valid = 1'b0; exec_ready = 1'b0; done_strobe = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        rd_check(2'd0, 64'h0, "base after reset");
        rd_check(2'd1, 64'h0, "groups after reset");
        rd_check(2'd2, 64'h0, "ctrl after reset");
        rd_check(2'd3, 64'h0, "status after reset");
        cycle();

        // R4: base alignment
        cur_req = "R4";
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_check(2'd0, 64'hFFFF_FFFF_FFFF_FF80, "base low bits");
        wr(2'd0, 64'h0000_1234_5678_9ABF);
        rd_check(2'd0, 64'h0000_1234_5678_9A80, "base masked");

        // R2: clamp of group count
        cur_req = "R2";
        wr(2'd1, 64'd9);
        rd_check(2'd1, 64'd3, "groups clamp");

        // R3/R6: one group leaves no usable space
        cur_req = "R3";
        wr(2'd1, 64'd1);
        wr(2'd2, 64'd1);
        push_valid = 1'b1; push_rec = rnd_rec();
        cycle();
        idle();
        rd_check(2'd3, 64'h0000_0000_0000_0002, "one group refuses push");
        cur_req = "R6";
        wr(2'd3, 64'd0);
        rd_check(2'd3, 64'h0000_0000_0000_0002, "flag kept on write 0");
        wr(2'd3, 64'd2);
        rd_check(2'd3, 64'h0000_0000_0000_0000, "flag cleared on write 1");

        // R3/R7: fill two groups with dispatch disabled
        cur_req = "R3";
        wr(2'd1, 64'd2);
        for (int i = 0; i < 41; i++) begin
            push_valid = 1'b1; push_rec = rnd_rec(); exec_ready = 1'b1;
            cycle();
        end
        idle();
        rd_check(2'd3, 64'h0000_0028_0000_0002, "full at 40 with drop");
        cur_req = "R7";
        check(exec_valid === 1'b0, "no dispatch while disabled", REC_W'(exec_valid), '0);
        wr(2'd3, 64'd2);

        // R5: accept disabled refuses pushes
        cur_req = "R5";
        wr(2'd2, 64'd0);
        push_valid = 1'b1; push_rec = rnd_rec();
        cycle();
        idle();
        rd_check(2'd3, 64'h0000_0028_0000_0002, "refused while accept off");
        wr(2'd3, 64'd2);

        // R7/R9: drain in order with accept off
        cur_req = "R9";
        wr(2'd3, 64'd1);
        exec_ready = 1'b1;
        for (int i = 0; i < 45; i++) cycle();
        idle();
        rd_check(2'd3, 64'h0000_0000_0028_0001, "drained, 40 in flight");

        // R8: completions and stray strobe at zero
        cur_req = "R8";
        done_strobe = 1'b1;
        for (int i = 0; i < 43; i++) cycle();
        idle();
        rd_check(2'd3, 64'h0000_0000_0000_0001, "in flight back to zero");
        wr(2'd3, 64'd0);

        // R2: group write empties the ring
        cur_req = "R2";
        wr(2'd2, 64'd1);
        for (int i = 0; i < 5; i++) begin
            push_valid = 1'b1; push_rec = rnd_rec();
            cycle();
        end
        idle();
        rd_check(2'd3, 64'h0000_0005_0000_0000, "five queued");
        wr(2'd1, 64'd2);
        rd_check(2'd3, 64'h0000_0000_0000_0000, "cleared by group write");

        // Random mix; R7 order and R8 counting checked by the model
        cur_req = "R7";
        wr(2'd1, 64'd3);
        wr(2'd3, 64'd1);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 2) wr(2'd2, 64'($urandom % 2));
            else if (r < 4) wr(2'd3, 64'($urandom % 4));
            else begin
                push_valid  = ($urandom % 2) == 0;
                push_rec    = rnd_rec();
                exec_ready  = ($urandom % 10) < 4;
                done_strobe = ($urandom % 10) < 3;
                cycle();
            end
        end
        idle();

        // R9: shutdown order: accept off, drain, dispatch off
        cur_req = "R9";
        wr(2'd2, 64'd0);
        exec_ready = 1'b1; done_strobe = 1'b1;
        for (int i = 0; i < 400; i++) cycle();
        idle();
        wr(2'd3, 64'd2);
        rd_check(2'd3, 64'h0000_0000_0000_0000, "shutdown idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule